// File: doc/BRIEF.md
# Multiprocessor Serial Port with Address Filtering

This block is an asynchronous serial port for a controller bus. It sends and receives frames with one start bit, eight data bits sent least significant bit first, an optional ninth bit and one stop bit. Every bit lasts sixteen pulses of an external oversampling tick. A small register file is written and read over a plain synchronous bus. It holds a control byte, a data location that sends on write and returns the last received byte on read, a given-address byte and its mask.

When the filter bit is set, the port stays silent on frames that are not meant for this node. In the nine-bit modes a frame is accepted only if it is an address frame (ninth bit 1) whose byte matches the given or broadcast pattern. In the eight-bit mode a frame is accepted only if its stop bit is valid and its byte matches. The top bit of the control byte is the upper mode bit or a sticky framing-error flag. An external select pin picks which one it is. A single interrupt line reports both the receive flag and the transmit flag.

Top module: `mpuart`

## Requirements
- R1: After reset the control byte reads 0x00, txd is 1 and irq is 0.
- R2: The control byte at bus address 0 holds, from bit 7 down to bit 0: MD_HI/FERR, MD_LO, FILT, RXEN, TX9, RX9, TXF, RXF. The mode is {MD_HI, MD_LO}: 01 is eight-bit, 10 and 11 are nine-bit, 00 is inactive. With err_view = 1, bit 7 reads and writes FERR and MD_HI keeps its value. With err_view = 0, bit 7 is MD_HI.
- R3: FERR is set by any received frame whose stop bit samples low. A later valid frame does not clear it. Only a bus write of 0 to bit 7 with err_view = 1 clears it.
- R4: With FILT = 1 in a nine-bit mode, RXF is set only when the received ninth bit is 1 and the byte matches the given or broadcast pattern.
- R5: With FILT = 1 in the eight-bit mode, RXF is set only when the stop bit is valid and the byte matches the given or broadcast pattern.
- R6: On an accepted frame, RX9 takes the received ninth bit in the nine-bit modes and the received stop bit in the eight-bit mode. Reading bus address 1 returns the accepted byte.
- R7: RXF rises in the middle of the received stop bit. TXF rises when the transmitted stop bit starts. Both stay set until the bus writes 0 to them. irq equals RXF OR TXF.
- R8: While RXEN is 0, incoming frames change neither RXF nor the receive buffer.
- R9: A bus write to address 1 while the port is idle and in an active mode sends start 0, the eight data bits LSB first, TX9 in the nine-bit modes, then stop 1, each bit 16 ticks long. A write to address 1 while a frame is being sent is ignored.
- R10: The given pattern matches when the byte equals the address register (bus address 2) at every bit where the mask register (bus address 3) is 1.
- R11: The broadcast pattern is address OR mask. The byte matches it when it has a 1 at every bit where that OR is 1.
- R12: A low pulse on rxd that has ended by the mid-point of the start bit is not taken as a frame. Each data bit is the majority of three samples at mid-bit, so a one-sample glitch there does not change it.
- R13: A frame that completes while RXF is still 1 is dropped. The receive buffer and RX9 keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| err_view | input | 1 | 1: control bit 7 is FERR; 0: it is MD_HI |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 data, 2 address, 3 mask |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| rxd | input | 1 | Serial input, idle high |
| txd | output | 1 | Serial output, idle high |
| irq | output | 1 | RXF OR TXF |

## Verification
A wrong bit or vote counter in the receiver shows up within one frame: the buffer holds a shifted byte, RX9 holds the wrong bit, or the flag rises before or after the middle of the stop bit. A fault in the address compare or the filter qualification shows up on the first filtered frame, as a receive flag that should not be there or one that never rises. A sticky flag that drops or a dropped frame that overwrites the buffer shows up on the next bus read. Transmit faults show on txd at the next bit centre, and the transmit flag is checked at the last bit centre before the stop bit and at the stop bit centre.

// File: rtl/mpuart_pkg.sv
// Shared register addresses and state encodings for the serial port.
package mpuart_pkg;
    localparam int REG_AW = 2;
    localparam logic [REG_AW-1:0] RA_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] RA_DATA = 2'd1;
    localparam logic [REG_AW-1:0] RA_ADDR = 2'd2;
    localparam logic [REG_AW-1:0] RA_MASK = 2'd3;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;
    typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_STOP} tx_state_e;
endpackage

// File: rtl/mpuart_addr_match.sv
// Masked address compare. The byte hits when it matches the given
// pattern (address where mask is 1) or the broadcast pattern (every
// 1 of address|mask present). Purely combinational.
module mpuart_addr_match #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] byte_in,
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] mask,
    output logic          hit
);
    logic [DW-1:0] bcast;
    logic          given_hit;
    logic          bcast_hit;

    // Compare against both patterns
    always_comb begin
        bcast     = addr | mask;
        given_hit = (((byte_in ^ addr) & mask) == '0);
        bcast_hit = ((byte_in & bcast) == bcast);
        hit       = given_hit | bcast_hit;
    end
endmodule

// File: rtl/mpuart_rx.sv
// Receiver. Synchronises rxd, confirms the start bit with one sample
// at mid-bit, takes every later bit as a 3-sample majority around
// mid-bit and pulses done at the stop bit centre. Assumes OSR is a
// power of two and SYNC >= 2.
module mpuart_rx
    import mpuart_pkg::*;
#(
    parameter int DW   = 8,
    parameter int OSR  = 16,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          enable,
    input  logic          nine_bit,
    input  logic          rxd,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          bit9,
    output logic          stop_ok
);
    localparam int CW  = $clog2(OSR);
    localparam int MID = OSR / 2;
    localparam int BW  = $clog2(DW + 3);
    localparam logic [CW-1:0] C_CHK  = CW'(MID - 1);
    localparam logic [CW-1:0] C_LAST = CW'(OSR - 1);
    localparam logic [CW-1:0] C_V0   = CW'(MID - 2);
    localparam logic [CW-1:0] C_V1   = CW'(MID - 1);
    localparam logic [CW-1:0] C_V2   = CW'(MID);

    rx_state_e     state;
    logic [SYNC-1:0] sync_q;
    logic          rxs;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bitn;
    logic [BW-1:0] stop_idx;
    logic [1:0]    vote_q;
    logic          maj;
    logic [DW-1:0] shreg;
    logic          b9_q;

    assign rxs  = sync_q[SYNC-1];
    assign data = shreg;

    // Two-or-more flop synchroniser for the asynchronous line
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC-2:0], rxd};
    end

    // Majority of the two held samples and the current one
    always_comb begin
        maj      = (vote_q[1] & vote_q[0]) | (vote_q[1] & rxs) | (vote_q[0] & rxs);
        stop_idx = nine_bit ? BW'(DW + 1) : BW'(DW);
    end

    // Frame state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            bitn    <= '0;
            vote_q  <= '0;
            shreg   <= '0;
            b9_q    <= 1'b0;
            done    <= 1'b0;
            bit9    <= 1'b0;
            stop_ok <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!enable) begin
                state <= RX_IDLE;
            end else if (tick) begin
                unique case (state)
                    RX_IDLE: begin
                        if (!rxs) begin
                            state <= RX_START;
                            cnt   <= CW'(1);
                        end
                    end
                    RX_START: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == C_CHK && rxs) begin
                            state <= RX_IDLE;
                        end else if (cnt == C_LAST) begin
                            state <= RX_BITS;
                            bitn  <= '0;
                        end
                    end
                    RX_BITS: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == C_V0 || cnt == C_V1) vote_q <= {vote_q[0], rxs};
                        if (cnt == C_V2) begin
                            bitn <= bitn + 1'b1;
                            if (bitn < BW'(DW)) begin
                                shreg <= {maj, shreg[DW-1:1]};
                            end else if (bitn == stop_idx) begin
                                stop_ok <= maj;
                                bit9    <= nine_bit ? b9_q : maj;
                                done    <= 1'b1;
                                state   <= RX_IDLE;
                            end else begin
                                b9_q <= maj;
                            end
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // R8: a disabled receiver reports no frame
    a_r8_no_done_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !done);
    // R12: a completion is a single-cycle pulse
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/mpuart_tx.sv
// Transmitter. On start it loads start bit, data and ninth bit into a
// shift register, sends each bit for OSR ticks, pulses stop_begin as
// the stop bit begins and returns idle after it. Assumes OSR is a
// power of two.
module mpuart_tx
    import mpuart_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic [DW-1:0] din,
    input  logic          nine_bit,
    input  logic          tb8,
    output logic          txd,
    output logic          busy,
    output logic          stop_begin
);
    localparam int CW = $clog2(OSR);
    localparam int FW = DW + 2;
    localparam int BW = $clog2(FW + 1);
    localparam logic [CW-1:0] C_LAST = CW'(OSR - 1);

    tx_state_e     state;
    logic [FW-1:0] sh;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bitn;
    logic [BW-1:0] last_idx;

    // Index of the final bit sent before the stop bit
    assign last_idx = nine_bit ? BW'(FW - 1) : BW'(FW - 2);
    assign txd      = (state == TX_SEND) ? sh[0] : 1'b1;
    assign busy     = (state != TX_IDLE);

    // Frame sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= TX_IDLE;
            sh         <= '1;
            cnt        <= '0;
            bitn       <= '0;
            stop_begin <= 1'b0;
        end else begin
            stop_begin <= 1'b0;
            unique case (state)
                TX_IDLE: begin
                    if (start) begin
                        sh    <= {tb8, din, 1'b0};
                        cnt   <= '0;
                        bitn  <= '0;
                        state <= TX_SEND;
                    end
                end
                TX_SEND: begin
                    if (tick) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == C_LAST) begin
                            sh   <= {1'b1, sh[FW-1:1]};
                            bitn <= bitn + 1'b1;
                            if (bitn == last_idx) begin
                                state      <= TX_STOP;
                                stop_begin <= 1'b1;
                            end
                        end
                    end
                end
                TX_STOP: begin
                    if (tick) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == C_LAST) state <= TX_IDLE;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // R9: every frame opens with a low start bit
    a_r9_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);
    // R9: the stop bit is high
    a_r9_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        stop_begin |-> txd);
endmodule

// File: rtl/mpuart.sv
// Serial port top. Holds the control byte, receive buffer and address
// filter registers, qualifies receive completions with the filter and
// routes bus writes to the transmitter. Hardware flag setting wins
// over a bus write in the same cycle.
module mpuart
    import mpuart_pkg::*;
#(
    parameter int DW   = 8,
    parameter int OSR  = 16,
    parameter int SYNC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              err_view,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rxd,
    output logic              txd,
    output logic              irq
);
    logic md_hi, md_lo, filt, rxen, tx9, rx9, txf, rxf, ferr;
    logic [DW-1:0] rx_buf, gaddr, gmask;
    logic nine_bit, active, ctrl_wr, data_wr;
    logic rx_done, rx_bit9, rx_stop_ok, hit, accept;
    logic [DW-1:0] rx_data;
    logic tx_busy, tx_stop_begin;

    // Mode decode and write strobes
    always_comb begin
        nine_bit = md_hi;
        active   = md_hi | md_lo;
        ctrl_wr  = bus_wr && (bus_addr == RA_CTRL);
        data_wr  = bus_wr && (bus_addr == RA_DATA);
    end

    mpuart_rx #(.DW(DW), .OSR(OSR), .SYNC(SYNC)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .enable   (rxen & active),
        .nine_bit (nine_bit),
        .rxd      (rxd),
        .done     (rx_done),
        .data     (rx_data),
        .bit9     (rx_bit9),
        .stop_ok  (rx_stop_ok)
    );

    mpuart_tx #(.DW(DW), .OSR(OSR)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick),
        .start      (data_wr & active & ~tx_busy),
        .din        (bus_wdata[DW-1:0]),
        .nine_bit   (nine_bit),
        .tb8        (tx9),
        .txd        (txd),
        .busy       (tx_busy),
        .stop_begin (tx_stop_begin)
    );

    mpuart_addr_match #(.DW(DW)) u_match (
        .byte_in (rx_data),
        .addr    (gaddr),
        .mask    (gmask),
        .hit     (hit)
    );

    // Filter qualification of a completed frame
    always_comb begin
        if (rxf)        accept = 1'b0;
        else if (!filt) accept = 1'b1;
        else if (nine_bit) accept = rx_bit9 & hit;
        else            accept = rx_stop_ok & hit;
    end

    // Control byte, flags and receive buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {md_hi, md_lo, filt, rxen, tx9, rx9, txf, rxf, ferr} <= '0;
            rx_buf <= '0;
        end else begin
            if (ctrl_wr) begin
                if (err_view) ferr  <= bus_wdata[7];
                else          md_hi <= bus_wdata[7];
                {md_lo, filt, rxen, tx9, rx9, txf, rxf} <= bus_wdata[6:0];
            end
            if (tx_stop_begin) txf <= 1'b1;
            if (rx_done) begin
                if (!rx_stop_ok) ferr <= 1'b1;
                if (accept) begin
                    rxf    <= 1'b1;
                    rx9    <= rx_bit9;
                    rx_buf <= rx_data;
                end
            end
        end
    end

    // Address and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gaddr <= '0;
            gmask <= '0;
        end else if (bus_wr) begin
            if (bus_addr == RA_ADDR) gaddr <= bus_wdata[DW-1:0];
            if (bus_addr == RA_MASK) gmask <= bus_wdata[DW-1:0];
        end
    end

    // Read mux
    always_comb begin
        unique case (bus_addr)
            RA_CTRL: bus_rdata = {(err_view ? ferr : md_hi), md_lo, filt, rxen, tx9, rx9, txf, rxf};
            RA_DATA: bus_rdata = 8'(rx_buf);
            RA_ADDR: bus_rdata = 8'(gaddr);
            default: bus_rdata = 8'(gmask);
        endcase
    end

    assign irq = rxf | txf;

    // R7: the receive flag stays up until the bus clears it
    a_r7_rxf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rxf && !ctrl_wr) |=> rxf);
    // R3: the error flag stays up until cleared through bit 7
    a_r3_ferr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ferr && !(ctrl_wr && err_view)) |=> ferr);
    // R13: a pending flag freezes the buffer and ninth bit
    a_r13_hold_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        (rxf && !ctrl_wr) |=> ($stable(rx_buf) && $stable(rx9)));
    // R4: a filtered nine-bit acceptance always carries ninth bit 1
    a_r4_addr_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rxf) && !$past(ctrl_wr) && filt && md_hi) |-> rx9);
    // R7: the transmit flag rises with the line at the stop level
    a_r7_txf_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(txf) && !$past(ctrl_wr)) |-> txd);
endmodule

// File: tb/mpuart_tb.sv
`timescale 1ns/1ps
module mpuart_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       err_view = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       rxd = 1'b1;
    logic       txd;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] rv;

    mpuart u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .err_view(err_view),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd), .irq(irq)
    );

    always #4 clk = ~clk;

    // 16x tick: one cycle in four
    initial begin
        forever begin
            repeat (3) @(negedge clk) baud_tick = 1'b0;
            @(negedge clk) baud_tick = 1'b1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic drive_bit(input logic v, input bit noisy);
        rxd = v;
        repeat (32) @(negedge clk);
        if (noisy) rxd = ~v;
        repeat (4) @(negedge clk);
        rxd = v;
        repeat (28) @(negedge clk);
    endtask

    // One frame; a bad stop is held low for 3/4 of the bit
    task automatic send_frame(input logic [7:0] d, input bit nine, input bit b9,
                              input bit stp, input bit noisy, input bit chk_mid,
                              input bit exp_irq);
        @(negedge clk);
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i], noisy);
        if (nine) drive_bit(b9, noisy);
        if (stp) begin
            rxd = 1'b1;
            repeat (16) @(negedge clk);
            if (chk_mid) chk("R7 flag low early in stop bit", irq, 0);
            repeat (40) @(negedge clk);
            if (chk_mid) chk("R7 flag high late in stop bit", irq, exp_irq);
            repeat (8) @(negedge clk);
        end else begin
            rxd = 1'b0;
            repeat (48) @(negedge clk);
            rxd = 1'b1;
            repeat (16) @(negedge clk);
        end
        repeat (64) @(negedge clk);
    endtask

    // Sends one byte and checks every bit centre on txd
    task automatic tx_check(input logic [7:0] d, input bit nine, input bit t9,
                            input bit busy_wr);
        logic [10:0] fr;
        int nb;
        nb = nine ? 10 : 9;
        fr = {1'b1, t9, d, 1'b0};
        if (!nine) fr = {2'b11, d, 1'b0};
        wr(2'd1, d);
        repeat (35) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            chk("R9 txd bit", txd, fr[i]);
            if (i == nb - 1) chk("R7 no transmit flag before stop", irq, 0);
            if (busy_wr && i == 2) begin
                bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = ~d;
                @(negedge clk);
                bus_wr = 1'b0;
                repeat (63) @(negedge clk);
            end else begin
                repeat (64) @(negedge clk);
            end
        end
        chk("R9 stop bit high", txd, 1);
        chk("R7 transmit flag at stop", irq, 1);
        repeat (64) @(negedge clk);
        chk("R9 line idle after frame", txd, 1);
    endtask

    function automatic bit m_accept(bit nine, bit filt, logic [7:0] d, bit b9, bit stp,
                                    logic [7:0] a, logic [7:0] m);
        logic [7:0] bc;
        bit hitv;
        bc = a | m;
        hitv = (((d ^ a) & m) == 8'h00) || ((d & bc) == bc);
        if (!filt) return 1'b1;
        if (nine) return b9 && hitv;
        return stp && hitv;
    endfunction

    initial begin
        #(8 * 190000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] ebuf;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, rv); chk("R1 control after reset", rv, 8'h00);
        chk("R1 txd idle", txd, 1);
        chk("R1 irq low", irq, 0);

        // R6 R7 R12: eight-bit mode, no filter, noisy mid-bit samples
        wr(2'd0, 8'h50);
        rd(2'd0, rv); chk("R2 control readback", rv, 8'h50);
        send_frame(8'hA5, 0, 0, 1, 1, 1, 1);
        rd(2'd1, rv); chk("R12 majority keeps byte", rv, 8'hA5);
        rd(2'd0, rv); chk("R6 stop bit in RX9", rv, 8'h55);

        // R13 frame while flag pending is dropped
        send_frame(8'h3C, 0, 0, 1, 0, 0, 0);
        rd(2'd1, rv); chk("R13 buffer kept", rv, 8'hA5);
        wr(2'd0, 8'h50);
        rd(2'd0, rv); chk("R7 flag cleared by write", rv, 8'h50);

        // R12 short start glitch
        @(negedge clk); rxd = 1'b0;
        repeat (8) @(negedge clk); rxd = 1'b1;
        repeat (200) @(negedge clk);
        rd(2'd0, rv); chk("R12 glitch not a frame", rv, 8'h50);

        // R8 receiver disabled
        wr(2'd0, 8'h40);
        send_frame(8'h11, 0, 0, 1, 0, 0, 0);
        rd(2'd0, rv); chk("R8 no flag when disabled", rv, 8'h40);
        rd(2'd1, rv); chk("R8 buffer kept when disabled", rv, 8'hA5);

        // R3 framing error, stickiness, clear, MD_HI untouched
        wr(2'd0, 8'h50);
        err_view = 1'b1;
        send_frame(8'h81, 0, 0, 0, 0, 0, 0);
        rd(2'd0, rv); chk("R3 error set with flag, RX9=0", rv, 8'hD1);
        rd(2'd1, rv); chk("R6 byte with bad stop", rv, 8'h81);
        wr(2'd0, 8'hD0);
        send_frame(8'h22, 0, 0, 1, 0, 0, 0);
        rd(2'd0, rv); chk("R3 error survives valid frame", rv, 8'hD5);
        wr(2'd0, 8'h50);
        rd(2'd0, rv); chk("R3 error cleared", rv, 8'h50);
        err_view = 1'b0;
        rd(2'd0, rv); chk("R2 MD_HI unaffected by error writes", rv[7], 0);

        // R4 R10 R11 nine-bit filtered reception
        wr(2'd2, 8'h40); wr(2'd3, 8'hF0);
        wr(2'd0, 8'hF0);
        send_frame(8'h4A, 1, 0, 1, 0, 0, 0);
        rd(2'd0, rv); chk("R4 data frame ignored", rv, 8'hF0);
        send_frame(8'h4A, 1, 1, 1, 0, 1, 1);
        rd(2'd0, rv); chk("R10 given hit, RX9=1", rv, 8'hF5);
        rd(2'd1, rv); chk("R10 given byte", rv, 8'h4A);
        wr(2'd0, 8'hF0);
        send_frame(8'hF3, 1, 1, 1, 0, 0, 0);
        rd(2'd1, rv); chk("R11 broadcast byte", rv, 8'hF3);
        wr(2'd0, 8'hF0);
        send_frame(8'h5A, 1, 1, 1, 0, 0, 0);
        rd(2'd0, rv); chk("R4 mismatched address ignored", rv, 8'hF0);
        rd(2'd1, rv); chk("R4 buffer kept", rv, 8'hF3);

        // R5 eight-bit filtered reception
        wr(2'd0, 8'h70);
        send_frame(8'h47, 0, 0, 1, 0, 0, 0);
        rd(2'd0, rv); chk("R5 match with valid stop", rv, 8'h75);
        wr(2'd0, 8'h70);
        err_view = 1'b1;
        send_frame(8'h47, 0, 0, 0, 0, 0, 0);
        rd(2'd0, rv); chk("R5 bad stop rejected, error set", rv, 8'hF0);
        wr(2'd0, 8'h70);
        err_view = 1'b0;

        // R9 R7 transmit: nine-bit with TX9=1 and busy write, then eight-bit
        wr(2'd0, 8'hC8);
        tx_check(8'h96, 1, 1, 1);
        wr(2'd0, 8'h40);
        chk("R7 irq low after clear", irq, 0);
        tx_check(8'h5B, 0, 0, 0);
        wr(2'd0, 8'h40);

        // Random filtered reception against the model
        rd(2'd1, ebuf);
        for (int it = 0; it < 30; it++) begin
            bit nine, filt, b9, stp, acc;
            logic [7:0] a, m, d, sel;
            nine = 1'($urandom % 2); filt = 1'($urandom % 2);
            b9 = 1'($urandom % 2); stp = (($urandom % 8) != 0);
            a = 8'($urandom); m = 8'($urandom); sel = 8'($urandom % 3);
            d = 8'($urandom);
            if (sel == 0) d = (a & m) | (d & ~m);
            else if (sel == 1) d = d | a | m;
            wr(2'd2, a); wr(2'd3, m);
            err_view = 1'b0;
            wr(2'd0, {nine, 1'b1, filt, 1'b1, 4'h0});
            err_view = 1'b1;
            wr(2'd0, {1'b0, 1'b1, filt, 1'b1, 4'h0});
            send_frame(d, nine, b9, stp, 0, 0, 0);
            acc = m_accept(nine, filt, d, b9, stp, a, m);
            if (acc) ebuf = d;
            rd(2'd0, rv);
            chk("R4 R5 R6 R3 random control", rv,
                {~stp, 1'b1, filt, 1'b1, 1'b0, acc & (nine ? b9 : stp), 1'b0, acc});
            rd(2'd1, rv); chk("R10 R11 random buffer", rv, ebuf);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule